// File: doc/BRIEF.md
# Strap-to-Serial Configuration Sequencer

This block holds the configuration of a dual-channel converter and decides where that configuration comes from. After reset it runs in strap mode. Two dual-purpose pins, the serial clock pin and the serial data pin, are read as static levels. The data pin picks the output standard and the clock pin picks the data format. In this mode the decoded outputs follow those pins directly.

The first falling edge of the active-low chip select moves the block into serial mode, and it stays there until the next hardware reset. On that edge the two pin levels are latched as the initial output-standard and data-format register values. From then on the same pins carry a 3-wire serial protocol that reads and writes a small register file. The register file holds a channel index, an operating mode with a self-clearing soft reset, clock path controls, full-scale reference controls and the output format controls.

All serial pins are oversampled by the system clock `clk_i` through synchronizers. The serial clock must therefore run several times slower than `clk_i`.

Top module: `cfg_mode_seq`

## Requirements
- R1: Before the first chip-select falling edge, `serial_mode_o` is 0, `out_lvds_o` follows `sdio_i`, and `data_fmt_o` is 01 when `sclk_i` is high and 00 when it is low. The pin-to-output path passes through the input synchronizers.
- R2: The first falling edge of `cs_ni` sets `serial_mode_o` to 1. It then stays 1 whatever the pins do, until `rst_ni` is asserted.
- R3: On that entry edge, the output-standard bit takes the `sdio_i` level (1 means LVDS DDR) and the format field takes 01 if `sclk_i` is high, else 00. Later pin levels have no effect on these outputs.
- R4: A frame starts at a chip-select falling edge, and every bit is sampled on a rising edge of `sclk_i`. The frame carries, in order: one R/W bit (1 means read), a 2-bit byte count W where the byte total is W+1, a 13-bit address sent MSB first, and the data bytes sent MSB first. Each write byte is stored when its eighth bit arrives.
- R5: In a multi-byte transfer the address goes up by one per byte. Bits clocked after the last counted byte are ignored.
- R6: In a read frame, `sdio_oe_o` rises after the last address bit and stays high through the data phase. `sdio_o` presents each data bit MSB first, valid before the sampling rising edge. `sdio_oe_o` is 0 in write frames and after `cs_ni` returns high.
- R7: Register 0x0003 bits [1:0] drive `chan_en_o` (bit 0 is channel A, bit 1 is channel B). The default is 11.
- R8: Register 0x0005 bits [1:0] drive `op_mode_o`, default 00. Writing bit 7 as 1 restores every register to its default, with the format and standard fields taken from the latched straps. That bit always reads back 0.
- R9: Register 0x0006 holds three clock controls: bit 0 `dcs_en_o` (default 1), bit 1 `clk_div2_o` (default 0) and bit 2 `clk_se_o` (default 0).
- R10: Register 0x0008 bits [2:0] hold the full-scale step and bit 3 drives `ref_int_en_o` (default 0). `fs_step_o` equals the step code for codes 0 to 6. Reserved code 7 drives 0, but the register still reads back 7.
- R11: Register 0x0011 bits [1:0] hold the format code and bit 3 the output standard. In serial mode `data_fmt_o` is 00 for offset binary, 01 for two's complement and 10 for Gray. Stored code 11 drives 00 and reads back 11.
- R12: Addresses outside the map read as 0x00, and writes to them change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock; format strap in strap mode |
| sdio_i | input | 1 | Serial data in; output-standard strap in strap mode |
| sdio_o | output | 1 | Serial read data |
| sdio_oe_o | output | 1 | Drive enable for serial read data |
| serial_mode_o | output | 1 | 1 once serial mode has been entered |
| out_lvds_o | output | 1 | Output standard: 1 LVDS DDR, 0 CMOS |
| data_fmt_o | output | 2 | Output data format code |
| chan_en_o | output | 2 | Channel select bits (B, A) |
| op_mode_o | output | 2 | Operating mode field |
| clk_se_o | output | 1 | Single-ended clock input select |
| clk_div2_o | output | 1 | Divide-by-2 clock path enable |
| dcs_en_o | output | 1 | Duty-cycle stabilizer enable |
| ref_int_en_o | output | 1 | Internal reference programming enable |
| fs_step_o | output | 3 | Full-scale attenuation step in dB (0 to 6) |

## Verification
The bench uses the default parameters: a 13-bit address, a 2-bit byte count and two synchronizer stages. The serial clock runs at twelve system clocks per period. With the 2-bit count, four-byte bursts and address rollover into neighbouring registers are within reach. The two-stage synchronizer sets the latency from a pin change to strap tracking and to the read data appearing before its sampling edge. Both are checked with margin at the ports.

// File: rtl/csq_pkg.sv
package csq_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned A_CHAN   = 'h0003;
  localparam int unsigned A_MODE   = 'h0005;
  localparam int unsigned A_CLK    = 'h0006;
  localparam int unsigned A_REF    = 'h0008;
  localparam int unsigned A_OUT    = 'h0011;
  localparam int unsigned SRST_BIT = 7;

  typedef enum logic [1:0] {
    FMT_OFFBIN = 2'b00,
    FMT_TWOS   = 2'b01,
    FMT_GRAY   = 2'b10,
    FMT_ALT    = 2'b11
  } fmt_e;

  typedef struct packed {
    logic [1:0] chan;
    logic [1:0] opm;
    logic       clk_se;
    logic       div2;
    logic       dcs;
    logic       ref_en;
    logic [2:0] step;
    fmt_e       fmt;
    logic       lvds;
  } cfg_t;

  function automatic cfg_t cfg_default(logic lvds, logic twos);
    cfg_t c;
    c.chan   = 2'b11;
    c.opm    = 2'b00;
    c.clk_se = 1'b0;
    c.div2   = 1'b0;
    c.dcs    = 1'b1;
    c.ref_en = 1'b0;
    c.step   = 3'd0;
    c.fmt    = twos ? FMT_TWOS : FMT_OFFBIN;
    c.lvds   = lvds;
    return c;
  endfunction
endpackage

// File: rtl/csq_sync.sv
module csq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= {STAGES{RST_VAL}};
        else         q <= {q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/csq_mode.sv
module csq_mode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_fall_i,
  input  logic sdio_s_i,
  input  logic sclk_s_i,
  output logic serial_o,
  output logic enter_o,
  output logic strap_lvds_o,
  output logic strap_twos_o
);
  logic serial_q, lvds_q, twos_q;

  assign enter_o = cs_fall_i && !serial_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      serial_q <= 1'b0;
      lvds_q   <= 1'b0;
      twos_q   <= 1'b0;
    end else if (enter_o) begin
      serial_q <= 1'b1;
      lvds_q   <= sdio_s_i;
      twos_q   <= sclk_s_i;
    end
  end

  assign serial_o     = serial_q;
  assign strap_lvds_o = lvds_q;
  assign strap_twos_o = twos_q;

  p_mode_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serial_q |=> serial_q);
  p_enter_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_o |=> !enter_o && serial_q);
endmodule

// File: rtl/csq_frame.sv
module csq_frame #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_s_i,
  input  logic              sclk_s_i,
  input  logic              sdio_s_i,
  input  logic [7:0]        rd_data_i,
  output logic              cs_fall_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              sdio_o,
  output logic              sdio_oe_o
);
  localparam int unsigned HDR_LEN = 1 + CNT_W + ADDR_W;
  localparam int unsigned HCNT_W  = $clog2(HDR_LEN + 1);

  logic              cs_d, sclk_d, sclk_rise;
  logic              active_q, done_q, rw_q, wr_en_q;
  logic [HCNT_W-1:0] hcnt_q;
  logic [HDR_LEN-2:0] hdr_q;
  logic [CNT_W-1:0]  nb_q, byte_q;
  logic [ADDR_W-1:0] addr_q, wr_addr_q;
  logic [2:0]        bcnt_q;
  logic [6:0]        sh_q;
  logic [7:0]        wr_data_q;
  logic              hdr_done, data_ph;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s_i;
      sclk_d <= sclk_s_i;
    end
  end

  assign cs_fall_o = cs_d && !cs_s_i;
  assign sclk_rise = sclk_s_i && !sclk_d;
  assign hdr_done  = (hcnt_q == HCNT_W'(HDR_LEN));
  assign data_ph   = active_q && hdr_done && !done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      done_q    <= 1'b0;
      rw_q      <= 1'b0;
      wr_en_q   <= 1'b0;
      hcnt_q    <= '0;
      hdr_q     <= '0;
      nb_q      <= '0;
      byte_q    <= '0;
      addr_q    <= '0;
      wr_addr_q <= '0;
      bcnt_q    <= '0;
      sh_q      <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (cs_s_i) begin
        active_q <= 1'b0;
      end else if (cs_fall_o) begin
        active_q <= 1'b1;
        done_q   <= 1'b0;
        hcnt_q   <= '0;
        bcnt_q   <= '0;
        byte_q   <= '0;
      end else if (active_q && sclk_rise && !done_q) begin
        if (!hdr_done) begin
          hdr_q  <= {hdr_q[HDR_LEN-3:0], sdio_s_i};
          hcnt_q <= hcnt_q + 1'b1;
          if (hcnt_q == HCNT_W'(HDR_LEN - 1)) begin
            rw_q   <= hdr_q[HDR_LEN-2];
            nb_q   <= hdr_q[HDR_LEN-3 -: CNT_W];
            addr_q <= {hdr_q[ADDR_W-2:0], sdio_s_i};
          end
        end else begin
          sh_q   <= {sh_q[5:0], sdio_s_i};
          bcnt_q <= bcnt_q + 1'b1;
          if (bcnt_q == 3'd7) begin
            if (!rw_q) begin
              wr_en_q   <= 1'b1;
              wr_addr_q <= addr_q;
              wr_data_q <= {sh_q, sdio_s_i};
            end
            addr_q <= addr_q + 1'b1;
            byte_q <= byte_q + 1'b1;
            if (byte_q == nb_q) done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign rd_addr_o = addr_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign sdio_oe_o = data_ph && rw_q;
  assign sdio_o    = sdio_oe_o ? rd_data_i[3'd7 - bcnt_q] : 1'b0;

  p_wr_spacing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |=> !wr_en_q);
  p_no_wr_after_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && active_q && $past(done_q)) |-> !wr_en_q);
  p_oe_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_i |=> !sdio_oe_o);
endmodule

// File: rtl/csq_regs.sv
module csq_regs
  import csq_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enter_i,
  input  logic              ent_lvds_i,
  input  logic              ent_twos_i,
  input  logic              strap_lvds_i,
  input  logic              strap_twos_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output cfg_t              cfg_o
);
  cfg_t cfg_q;
  logic soft_rst;

  assign soft_rst = wr_en_i && (wr_addr_i == ADDR_W'(A_MODE)) && wr_data_i[SRST_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= cfg_default(1'b0, 1'b0);
    end else if (enter_i) begin
      cfg_q <= cfg_default(ent_lvds_i, ent_twos_i);
    end else if (soft_rst) begin
      cfg_q <= cfg_default(strap_lvds_i, strap_twos_i);
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(A_CHAN)) cfg_q.chan <= wr_data_i[1:0];
      if (wr_addr_i == ADDR_W'(A_MODE)) cfg_q.opm  <= wr_data_i[1:0];
      if (wr_addr_i == ADDR_W'(A_CLK)) begin
        cfg_q.dcs    <= wr_data_i[0];
        cfg_q.div2   <= wr_data_i[1];
        cfg_q.clk_se <= wr_data_i[2];
      end
      if (wr_addr_i == ADDR_W'(A_REF)) begin
        cfg_q.step   <= wr_data_i[2:0];
        cfg_q.ref_en <= wr_data_i[3];
      end
      if (wr_addr_i == ADDR_W'(A_OUT)) begin
        cfg_q.fmt  <= fmt_e'(wr_data_i[1:0]);
        cfg_q.lvds <= wr_data_i[3];
      end
    end
  end

  always_comb begin
    rd_data_o = 8'h00;
    if (rd_addr_i == ADDR_W'(A_CHAN)) rd_data_o = {6'b0, cfg_q.chan};
    if (rd_addr_i == ADDR_W'(A_MODE)) rd_data_o = {6'b0, cfg_q.opm};
    if (rd_addr_i == ADDR_W'(A_CLK))  rd_data_o = {5'b0, cfg_q.clk_se, cfg_q.div2, cfg_q.dcs};
    if (rd_addr_i == ADDR_W'(A_REF))  rd_data_o = {4'b0, cfg_q.ref_en, cfg_q.step};
    if (rd_addr_i == ADDR_W'(A_OUT))  rd_data_o = {4'b0, cfg_q.lvds, 1'b0, cfg_q.fmt};
  end

  assign cfg_o = cfg_q;

  p_strap_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_i |=> (cfg_q.lvds == $past(ent_lvds_i)) &&
                (cfg_q.fmt == ($past(ent_twos_i) ? FMT_TWOS : FMT_OFFBIN)));
  p_soft_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst && !enter_i) |=> (cfg_q.chan == 2'b11) && (cfg_q.opm == 2'b00) &&
                               cfg_q.dcs && !cfg_q.div2 && !cfg_q.ref_en);
endmodule

// File: rtl/cfg_mode_seq.sv
module cfg_mode_seq
  import csq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned CNT_W       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sclk_i,
  input  logic       sdio_i,
  output logic       sdio_o,
  output logic       sdio_oe_o,
  output logic       serial_mode_o,
  output logic       out_lvds_o,
  output logic [1:0] data_fmt_o,
  output logic [1:0] chan_en_o,
  output logic [1:0] op_mode_o,
  output logic       clk_se_o,
  output logic       clk_div2_o,
  output logic       dcs_en_o,
  output logic       ref_int_en_o,
  output logic [2:0] fs_step_o
);
  logic cs_s, sclk_s, sdio_s;
  logic cs_fall, enter, serial, strap_lvds, strap_twos;
  logic wr_en;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [7:0] wr_data, rd_data;
  cfg_t cfg;

  csq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cs_ni), .q_o(cs_s));
  csq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i), .q_o(sclk_s));
  csq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdio (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sdio_i), .q_o(sdio_s));

  csq_frame #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_s_i(cs_s), .sclk_s_i(sclk_s),
    .sdio_s_i(sdio_s), .rd_data_i(rd_data), .cs_fall_o(cs_fall),
    .rd_addr_o(rd_addr), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o));

  csq_mode u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_fall_i(cs_fall), .sdio_s_i(sdio_s),
    .sclk_s_i(sclk_s), .serial_o(serial), .enter_o(enter),
    .strap_lvds_o(strap_lvds), .strap_twos_o(strap_twos));

  csq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .enter_i(enter),
    .ent_lvds_i(sdio_s), .ent_twos_i(sclk_s),
    .strap_lvds_i(strap_lvds), .strap_twos_i(strap_twos),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .cfg_o(cfg));

  // strap mode: outputs track the synchronized pin levels
  always_comb begin
    if (serial) begin
      out_lvds_o = cfg.lvds;
      data_fmt_o = (cfg.fmt == FMT_ALT) ? FMT_OFFBIN : cfg.fmt;
    end else begin
      out_lvds_o = sdio_s;
      data_fmt_o = sclk_s ? FMT_TWOS : FMT_OFFBIN;
    end
  end

  assign serial_mode_o = serial;
  assign chan_en_o     = cfg.chan;
  assign op_mode_o     = cfg.opm;
  assign clk_se_o      = cfg.clk_se;
  assign clk_div2_o    = cfg.div2;
  assign dcs_en_o      = cfg.dcs;
  assign ref_int_en_o  = cfg.ref_en;
  assign fs_step_o     = (cfg.step == 3'd7) ? 3'd0 : cfg.step;

  p_fmt_legal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_fmt_o != 2'b11);
  p_fs_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_step_o != 3'd7);
  p_oe_serial_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdio_oe_o |-> serial_mode_o);
endmodule

// File: tb/cfg_mode_seq_bench.sv
module cfg_mode_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, sclk_i = 1'b0, sdio_i = 1'b0;
  logic sdio_o, sdio_oe_o, serial_mode_o, out_lvds_o;
  logic [1:0] data_fmt_o, chan_en_o, op_mode_o;
  logic clk_se_o, clk_div2_o, dcs_en_o, ref_int_en_o;
  logic [2:0] fs_step_o;
  int checks = 0, errors = 0;
  logic oe_bad;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_mode_seq u_cfg_mode_seq (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk_i), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o), .serial_mode_o(serial_mode_o),
    .out_lvds_o(out_lvds_o), .data_fmt_o(data_fmt_o), .chan_en_o(chan_en_o),
    .op_mode_o(op_mode_o), .clk_se_o(clk_se_o), .clk_div2_o(clk_div2_o),
    .dcs_en_o(dcs_en_o), .ref_int_en_o(ref_int_en_o), .fs_step_o(fs_step_o));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    sdio_i = b; sclk_i = 1'b0; idle(HALF);
    sclk_i = 1'b1; idle(HALF);
  endtask

  task automatic send_hdr(logic rw, logic [1:0] w, logic [12:0] a);
    send_bit(rw); send_bit(w[1]); send_bit(w[0]);
    for (int i = 12; i >= 0; i--) send_bit(a[i]);
  endtask

  // write n bytes (d[31:24] first) plus 'extra' trailing bytes of ones
  task automatic wr(logic [12:0] a, int n, logic [31:0] d, int extra);
    logic [31:0] v = d;
    cs_ni = 1'b0; idle(HALF);
    send_hdr(1'b0, 2'(n-1), a);
    for (int b = 0; b < n + extra; b++)
      for (int i = 0; i < 8; i++) begin
        send_bit(b < n ? v[31] : 1'b1);
        if (sdio_oe_o !== 1'b0) oe_bad = 1'b1;
        v = v << 1;
      end
    sclk_i = 1'b0; idle(HALF);
    cs_ni = 1'b1; idle(HALF);
  endtask

  task automatic rd(logic [12:0] a, int n, output logic [31:0] d);
    d = '0;
    cs_ni = 1'b0; idle(HALF);
    send_hdr(1'b1, 2'(n-1), a);
    for (int i = 0; i < 8*n; i++) begin
      sdio_i = 1'b0; sclk_i = 1'b0; idle(HALF);
      if (sdio_oe_o !== 1'b1) oe_bad = 1'b1;
      d = {d[30:0], sdio_o};
      sclk_i = 1'b1; idle(HALF);
    end
    sclk_i = 1'b0; idle(HALF);
    cs_ni = 1'b1; idle(HALF);
  endtask

  task automatic t_reset;
    check("R2 reset serial_mode", serial_mode_o, 0);
    check("R7 reset chan_en", chan_en_o, 2'b11);
    check("R9 reset dcs", dcs_en_o, 1);
    check("R6 reset oe", sdio_oe_o, 0);
  endtask

  task automatic t_strap_mode;
    sdio_i = 0; sclk_i = 0; idle(5);
    check("R1 strap lvds low", out_lvds_o, 0);
    check("R1 strap fmt low", data_fmt_o, 2'b00);
    sdio_i = 1; sclk_i = 1; idle(5);
    check("R1 strap lvds high", out_lvds_o, 1);
    check("R1 strap fmt high", data_fmt_o, 2'b01);
    check("R1 still strap mode", serial_mode_o, 0);
  endtask

  task automatic t_enter;
    // straps high at the falling edge; first frame writes chan index = 01
    cs_ni = 1'b0; idle(HALF);
    check("R2 entered serial", serial_mode_o, 1);
    send_hdr(1'b0, 2'b00, 13'h0003);
    for (int i = 7; i >= 0; i--) send_bit(i == 0);
    sclk_i = 0; sdio_i = 0; idle(HALF);
    cs_ni = 1'b1; idle(HALF);
    check("R3 strap lvds latched", out_lvds_o, 1);
    check("R3 strap fmt latched", data_fmt_o, 2'b01);
    check("R7 chan write", chan_en_o, 2'b01);
    check("R2 sticky after frame", serial_mode_o, 1);
  endtask

  task automatic t_clock_reg;
    logic [31:0] d;
    wr(13'h0006, 1, 32'h0600_0000, 0);
    check("R9 dcs", dcs_en_o, 0);
    check("R9 div2", clk_div2_o, 1);
    check("R9 single-ended", clk_se_o, 1);
    rd(13'h0006, 1, d);
    check("R6 R9 readback", d, 32'h06);
  endtask

  task automatic t_ref_reg;
    logic [31:0] d;
    wr(13'h0008, 1, 32'h0D00_0000, 0);
    check("R10 step 5", fs_step_o, 5);
    check("R10 ref_en", ref_int_en_o, 1);
    wr(13'h0008, 1, 32'h0F00_0000, 0);
    check("R10 reserved step", fs_step_o, 0);
    rd(13'h0008, 1, d);
    check("R10 reserved readback", d, 32'h0F);
  endtask

  task automatic t_out_reg;
    logic [31:0] d;
    wr(13'h0011, 1, 32'h0200_0000, 0);
    check("R11 gray", data_fmt_o, 2'b10);
    check("R11 cmos", out_lvds_o, 0);
    wr(13'h0011, 1, 32'h0B00_0000, 0);
    check("R11 code 11 maps", data_fmt_o, 2'b00);
    check("R11 lvds bit", out_lvds_o, 1);
    rd(13'h0011, 1, d);
    check("R11 readback", d, 32'h0B);
  endtask

  task automatic t_multi;
    logic [31:0] d;
    wr(13'h0005, 2, 32'h0205_0000, 0);
    check("R5 first byte opm", op_mode_o, 2'b10);
    check("R5 second byte dcs", dcs_en_o, 1);
    check("R5 second byte se", clk_se_o, 1);
    check("R5 second byte div2", clk_div2_o, 0);
    rd(13'h0005, 2, d);
    check("R5 R6 burst read", d, 32'h0205);
    wr(13'h0005, 1, 32'h0100_0000, 1);
    check("R5 counted byte", op_mode_o, 2'b01);
    check("R5 trailing byte ignored", clk_div2_o, 0);
    check("R5 trailing byte ignored se", clk_se_o, 1);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(13'h0004, 1, 32'hFF00_0000, 0);
    rd(13'h0004, 1, d);
    check("R12 unmapped read", d, 32'h00);
    check("R12 no effect chan", chan_en_o, 2'b01);
    check("R12 no effect opm", op_mode_o, 2'b01);
  endtask

  task automatic t_soft_reset;
    logic [31:0] d;
    wr(13'h0005, 1, 32'h8000_0000, 0);
    check("R8 chan default", chan_en_o, 2'b11);
    check("R8 opm default", op_mode_o, 0);
    check("R8 div2 default", clk_div2_o, 0);
    check("R8 se default", clk_se_o, 0);
    check("R8 ref default", ref_int_en_o, 0);
    check("R8 fmt from strap", data_fmt_o, 2'b01);
    check("R8 lvds from strap", out_lvds_o, 1);
    rd(13'h0005, 1, d);
    check("R8 self-clear", d, 32'h00);
  endtask

  task automatic t_oe;
    check("R6 oe rules in frames", oe_bad, 0);
    check("R6 oe idle", sdio_oe_o, 0);
    sdio_i = 0; sclk_i = 1; idle(5);
    check("R3 pins ignored lvds", out_lvds_o, 1);
    check("R3 pins ignored fmt", data_fmt_o, 2'b01);
    sclk_i = 0;
  endtask

  task automatic t_hard_reset;
    rst_ni = 0; idle(3); rst_ni = 1; idle(5);
    check("R2 reset leaves serial", serial_mode_o, 0);
    check("R1 strap after reset", data_fmt_o, 2'b00);
  endtask

  initial begin
    oe_bad = 1'b0;
    idle(4); rst_ni = 1'b1; idle(4);
    t_reset();
    t_strap_mode();
    t_enter();
    t_clock_reg();
    t_ref_reg();
    t_out_reg();
    t_multi();
    t_unmapped();
    t_soft_reset();
    t_oe();
    t_hard_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule